// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block decides which of five interrupt sources a 16550-style serial port reports, and it drives that port's interrupt line. It takes in the interrupt enable bits, the receiver error bits, the receive data and FIFO trigger state, the character-timeout flag and the modem-status change bits. From these it forms the identification byte that software reads. It also owns the flag that says "transmitter holding register empty, not yet acknowledged". That flag is set when the holding register drains or when the enable for it is switched on. It is cleared when software writes a new character, when it switches the enable off, or when it reads the identification byte while that byte reports this source.

The surrounding port logic instantiates the block next to its register file. It passes in the enable register write strobe with its data, the identification read strobe, the transmit write strobe and the holding register status. The identification byte and the interrupt line are both registered. Each is re-evaluated on every clock from the state present at that edge.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt line is low, the enable register reads 0 and the transmitter-empty pending flag is 0.
- R2: When several sources are active at once, exactly one is reported. From highest to lowest the order is: receiver line status, character timeout, received data, transmitter empty, modem status.
- R3: Receiver line status is active when enable bit 2 is set and any of the four error inputs (`lsr_err`) is set. It reports code 0x6 in bits 3:0.
- R4: Character timeout is active when enable bit 0 is set and `timeout_pend` is high. It reports code 0xC.
- R5: Received data is active when enable bit 0 is set and `data_ready` is high. With FIFOs enabled, `rx_level` must also be at or above `rx_trigger`. It reports code 0x4.
- R6: Transmitter empty is active when enable bit 1 is set and the pending flag is set, and it reports code 0x2. Modem status is active when enable bit 3 is set and any `msr_delta` bit is set, and it reports code 0x0. With no active source the code is 0x1.
- R7: The pending flag is set by `thr_empty_evt`. A write that turns enable bit 1 from 0 to 1 sets the flag when `thr_empty` is high and clears it otherwise. A write that turns bit 1 from 1 to 0 clears it.
- R8: An identification read (`iir_rd`) clears the pending flag when the byte currently presented reports code 0x2. A read while any other code is presented leaves the flag unchanged.
- R9: A transmit write (`thr_wr`) clears the pending flag. It takes precedence over every set or clear arriving in the same cycle. A read-clear in turn takes precedence over the enable-change and empty-event updates.
- R10: Bits 7:6 of the identification byte are 11 while `fifo_en` is high and 00 otherwise. Bits 5:4 are always 0.
- R11: Only bits 3:0 of the enable write data are stored. The upper four bits are ignored.
- R12: The interrupt line is high exactly when bits 3:0 of the identification byte differ from 0x1, and the two change on the same clock.
- R13: The identification byte and the interrupt line reflect the inputs and register state sampled at the previous clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| thr_wr | input | 1 | Transmit holding register write strobe |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| thr_empty_evt | input | 1 | Holding register has just become empty (pulse) |
| iir_rd | input | 1 | Identification byte read strobe |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive FIFO trigger level |
| data_ready | input | 1 | Receive data available |
| lsr_err | input | 4 | Break, framing, parity and overrun flags |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| ier | output | 4 | Stored enable register |
| iir | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt line |
| txe_pending | output | 1 | Transmitter-empty pending flag |

## Verification
The hardest situation to reach is a read that should clear the transmitter-empty flag racing against the other updates to that flag. This covers a read landing while a higher-priority source masks code 0x2, and a read in the same cycle as a transmit write, an enable toggle or a drain event. Directed sequences first raise the flag through the enable-on path and then through the drain event. They read the identification byte once while line status hides the flag and once while the flag is shown, and then collide a transmit write with a drain event. A long random phase then toggles all strobes and status inputs together. A behavioural reference model tracks the flag and the reported code every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC  = 5;
  localparam int IER_BITS = 4;

  // source index: lower index has higher priority
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_TXE     = 3;
  localparam int SRC_MODEM   = 4;

  // enable register bit positions
  localparam int EN_RXDATA = 0;
  localparam int EN_TXE    = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_TXE     = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  // isolate the lowest set request bit (highest priority)
  function automatic logic [NUM_SRC-1:0] first_set(input logic [NUM_SRC-1:0] req);
    first_set = req & (~req + NUM_SRC'(1));
  endfunction

  function automatic iid_e code_of(input logic [NUM_SRC-1:0] grant);
    iid_e c;
    c = IID_NONE;
    if (grant[SRC_LINE])    c = IID_LINE;
    if (grant[SRC_TIMEOUT]) c = IID_TIMEOUT;
    if (grant[SRC_RXDATA])  c = IID_RXDATA;
    if (grant[SRC_TXE])     c = IID_TXE;
    if (grant[SRC_MODEM])   c = IID_MODEM;
    return c;
  endfunction

  function automatic logic [1:0] fifo_flags(input logic fe);
    return fe ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [7:0]          wdata,
  output logic [IER_BITS-1:0] ier_q,
  output logic                txe_en_rise,
  output logic                txe_en_fall
);

  logic [IER_BITS-1:0] wr_low;
  assign wr_low = wdata[IER_BITS-1:0];

  assign txe_en_rise = wr &&  wr_low[EN_TXE] && !ier_q[EN_TXE];
  assign txe_en_fall = wr && !wr_low[EN_TXE] &&  ier_q[EN_TXE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ier_q <= '0;
    else if (wr) ier_q <= wr_low;
  end

  // R11: only the low nibble is kept
  a_r11_low_nibble_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ier_q == $past(wdata[IER_BITS-1:0]));

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ier_q));

endmodule

// File: rtl/uart_txe_pend.sv
module uart_txe_pend
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       thr_wr,
  input  logic       thr_empty,
  input  logic       empty_evt,
  input  logic       iir_rd,
  input  logic [3:0] iir_code,
  input  logic       txe_en_rise,
  input  logic       txe_en_fall,
  output logic       pend_q
);

  logic clr_by_write, clr_by_read, set_by_enable, clr_by_enable, set_by_empty;
  logic pend_d;

  assign clr_by_write  = thr_wr;
  assign clr_by_read   = iir_rd && (iir_code == IID_TXE);
  assign set_by_enable = txe_en_rise && thr_empty;
  assign clr_by_enable = txe_en_fall || (txe_en_rise && !thr_empty);
  assign set_by_empty  = empty_evt;

  always_comb begin
    pend_d = pend_q;
    if (clr_by_write)       pend_d = 1'b0;
    else if (clr_by_read)   pend_d = 1'b0;
    else if (set_by_enable) pend_d = 1'b1;
    else if (clr_by_enable) pend_d = 1'b0;
    else if (set_by_empty)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R9: a transmit write always wins
  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend_q);

  // R8: reading while the transmitter code is shown acknowledges it
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_code == IID_TXE) |=> !pend_q);

  // R7: turning the enable on over an empty holding register raises the flag
  a_r7_enable_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_en_rise && thr_empty && !thr_wr && !(iir_rd && iir_code == IID_TXE)) |=> pend_q);

  // R7: turning the enable off drops the flag
  a_r7_enable_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    txe_en_fall |=> !pend_q);

endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [IER_BITS-1:0] ier,
  input  logic [3:0]          lsr_err,
  input  logic                timeout_pend,
  input  logic                data_ready,
  input  logic                fifo_en,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [LVL_W-1:0]    rx_trigger,
  input  logic                txe_pend,
  input  logic [3:0]          msr_delta,
  output logic [NUM_SRC-1:0]  req
);

  logic rx_trig_met;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] en;

  assign rx_trig_met = !fifo_en || (rx_level >= rx_trigger);

  assign raw[SRC_LINE]    = |lsr_err;
  assign raw[SRC_TIMEOUT] = timeout_pend;
  assign raw[SRC_RXDATA]  = data_ready && rx_trig_met;
  assign raw[SRC_TXE]     = txe_pend;
  assign raw[SRC_MODEM]   = |msr_delta;

  assign en[SRC_LINE]    = ier[EN_LINE];
  assign en[SRC_TIMEOUT] = ier[EN_RXDATA];
  assign en[SRC_RXDATA]  = ier[EN_RXDATA];
  assign en[SRC_TXE]     = ier[EN_TXE];
  assign en[SRC_MODEM]   = ier[EN_MODEM];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    assign req[s] = raw[s] && en[s];
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               fifo_en,
  output logic [7:0]         iir_q,
  output logic               irq_q
);

  logic [NUM_SRC-1:0] grant;
  iid_e               code;

  assign grant = first_set(req);
  assign code  = code_of(grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {4'h0, IID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {fifo_flags(fifo_en), 2'b00, code};
      irq_q <= (code != IID_NONE);
    end
  end

  // R2: never more than one source granted
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: line status outranks everything
  a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[SRC_LINE] |=> iir_q[3:0] == IID_LINE);

  // R4: timeout outranks received data
  a_r4_timeout_over_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req[SRC_TIMEOUT] && !req[SRC_LINE]) |=> iir_q[3:0] == IID_TIMEOUT);

  // R10: FIFO flag bits follow the mode one cycle later
  a_r10_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> iir_q[7:4] == {$past(fifo_en), $past(fifo_en), 2'b00});

  // R12: line and code agree
  a_r12_irq_tracks_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (iir_q[3:0] != IID_NONE));

  // R13: no request, no interrupt on the following cycle
  a_r13_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> !irq_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  localparam int LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             thr_wr,
  input  logic             thr_empty,
  input  logic             thr_empty_evt,
  input  logic             iir_rd,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trigger,
  input  logic             data_ready,
  input  logic [3:0]       lsr_err,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier,
  output logic [7:0]       iir,
  output logic             irq,
  output logic             txe_pending
);

  logic [IER_BITS-1:0] ier_q;
  logic                txe_en_rise, txe_en_fall;
  logic                pend_q;
  logic [NUM_SRC-1:0]  req;
  logic [7:0]          iir_q;
  logic                irq_q;

  uart_ier_reg u_ier (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ier_wr),
    .wdata       (ier_wdata),
    .ier_q       (ier_q),
    .txe_en_rise (txe_en_rise),
    .txe_en_fall (txe_en_fall)
  );

  uart_txe_pend u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_wr      (thr_wr),
    .thr_empty   (thr_empty),
    .empty_evt   (thr_empty_evt),
    .iir_rd      (iir_rd),
    .iir_code    (iir_q[3:0]),
    .txe_en_rise (txe_en_rise),
    .txe_en_fall (txe_en_fall),
    .pend_q      (pend_q)
  );

  uart_irq_req #(.LVL_W(LVL_W)) u_req (
    .ier          (ier_q),
    .lsr_err      (lsr_err),
    .timeout_pend (timeout_pend),
    .data_ready   (data_ready),
    .fifo_en      (fifo_en),
    .rx_level     (rx_level),
    .rx_trigger   (rx_trigger),
    .txe_pend     (pend_q),
    .msr_delta    (msr_delta),
    .req          (req)
  );

  uart_irq_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .fifo_en (fifo_en),
    .iir_q   (iir_q),
    .irq_q   (irq_q)
  );

  assign ier         = ier_q;
  assign iir         = iir_q;
  assign irq         = irq_q;
  assign txe_pending = pend_q;

  // R6: with the transmitter source enabled and nothing above it, its code follows
  a_r6_txe_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ier_q[EN_TXE] && req[SRC_LINE +: 3] == 3'b000) |=> iir_q[3:0] == IID_TXE);

endmodule

// File: tb/uart_irq_prio_test.sv
module uart_irq_prio_test;

  localparam int RX_DEPTH = 16;
  localparam int LVL_W    = $clog2(RX_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, thr_wr = 0, thr_empty = 0, thr_empty_evt = 0, iir_rd = 0;
  logic fifo_en = 0, data_ready = 0, timeout_pend = 0;
  logic [7:0] ier_wdata = '0;
  logic [LVL_W-1:0] rx_level = '0, rx_trigger = '0;
  logic [3:0] lsr_err = '0, msr_delta = '0;
  logic [3:0] ier;
  logic [7:0] iir;
  logic irq, txe_pending;

  always #4 clk = ~clk;

  uart_irq_prio #(.RX_DEPTH(RX_DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .thr_empty(thr_empty), .thr_empty_evt(thr_empty_evt),
    .iir_rd(iir_rd), .fifo_en(fifo_en), .rx_level(rx_level),
    .rx_trigger(rx_trigger), .data_ready(data_ready), .lsr_err(lsr_err),
    .timeout_pend(timeout_pend), .msr_delta(msr_delta), .ier(ier),
    .iir(iir), .irq(irq), .txe_pending(txe_pending)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit armed = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_ier, m_iir;
  bit m_pend, m_irq;

  always @(posedge clk or negedge rst_n) begin
    int code;
    bit np;
    if (!rst_n) begin
      m_ier = 0; m_pend = 0; m_iir = 8'h01; m_irq = 0;
    end else begin
      if ((m_ier & 4) != 0 && lsr_err != 0)                               code = 'h6;
      else if ((m_ier & 1) != 0 && timeout_pend)                          code = 'hC;
      else if ((m_ier & 1) != 0 && data_ready &&
               (!fifo_en || int'(rx_level) >= int'(rx_trigger)))          code = 'h4;
      else if ((m_ier & 2) != 0 && m_pend)                                code = 'h2;
      else if ((m_ier & 8) != 0 && msr_delta != 0)                        code = 'h0;
      else                                                                code = 'h1;
      np = m_pend;
      if (thr_wr) np = 0;
      else if (iir_rd && (m_iir % 16) == 2) np = 0;
      else if (ier_wr && (((m_ier ^ int'(ier_wdata)) & 2) != 0)) np = ier_wdata[1] && thr_empty;
      else if (thr_empty_evt) np = 1;
      m_iir = (fifo_en ? 'hC0 : 0) | code;
      m_irq = (code != 1);
      m_pend = np;
      if (ier_wr) m_ier = int'(ier_wdata) & 15;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("iir", int'(iir), m_iir);
      chk("irq (R12)", int'(irq), int'(m_irq));
      chk("ier (R11)", int'(ier), m_ier);
      chk("txe_pending", int'(txe_pending), int'(m_pend));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic write_ier(logic [7:0] v);
    ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0; ier_wdata = '0;
  endtask

  task automatic read_iir();
    iir_rd = 1; tick(); iir_rd = 0;
  endtask

  initial begin
    // R1 reset state observed while and after reset
    tick(); armed = 1; tick(2);
    rst_n = 1; tick(2);

    cur_req = "R11";
    write_ier(8'hFF); tick();
    write_ier(8'hF0); tick();

    cur_req = "R2";
    thr_empty = 1;
    lsr_err = 4'b0100; timeout_pend = 1; data_ready = 1; msr_delta = 4'b0001;
    write_ier(8'h0F); tick(2);          // line status shown (R3)
    cur_req = "R8";
    read_iir(); tick();                 // pending hidden by line status, must stay
    cur_req = "R4";
    lsr_err = 0; tick(2);
    cur_req = "R5";
    timeout_pend = 0; tick(2);
    fifo_en = 1; rx_trigger = 5'd8; rx_level = 5'd7; tick(2);   // below trigger
    rx_level = 5'd8; tick(2);                                  // at trigger
    cur_req = "R10";
    fifo_en = 0; tick(2);
    cur_req = "R6";
    data_ready = 0; tick(2);            // transmitter code shown
    cur_req = "R8";
    read_iir(); tick(2);                // cleared, modem shown
    cur_req = "R6";
    msr_delta = 0; tick(2);

    cur_req = "R7";
    thr_empty_evt = 1; tick(); thr_empty_evt = 0; tick(2);
    write_ier(8'h0D); tick(2);          // enable off drops flag
    thr_empty = 0; write_ier(8'h0F); tick(2);   // enable on while busy: no flag
    thr_empty = 1; write_ier(8'h0D); write_ier(8'h0F); tick(2);

    cur_req = "R9";
    thr_wr = 1; thr_empty_evt = 1; tick(); thr_wr = 0; thr_empty_evt = 0; tick(2);
    thr_empty_evt = 1; iir_rd = 1; tick(); thr_empty_evt = 0; iir_rd = 0; tick(2);

    cur_req = "R2 R12 R13";
    for (int k = 0; k < 4000; k++) begin
      ier_wr        = ($urandom_range(7) == 0);
      ier_wdata     = 8'($urandom);
      thr_wr        = ($urandom_range(9) == 0);
      thr_empty     = $urandom_range(1) == 1;
      thr_empty_evt = ($urandom_range(5) == 0);
      iir_rd        = ($urandom_range(3) == 0);
      fifo_en       = $urandom_range(1) == 1;
      rx_level      = LVL_W'($urandom_range(RX_DEPTH));
      rx_trigger    = LVL_W'($urandom_range(RX_DEPTH));
      data_ready    = $urandom_range(1) == 1;
      lsr_err       = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
      timeout_pend  = ($urandom_range(3) == 0);
      msr_delta     = ($urandom_range(1) == 0) ? 4'($urandom) : 4'h0;
      tick();
    end
    ier_wr = 0; thr_wr = 0; thr_empty_evt = 0; iir_rd = 0;
    tick(2);

    cur_req = "R1";
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    finish_run();
  end

endmodule